// File: doc/BRIEF.md
# Echo-Clocked Read Capture and Half-Rate Deserializer

This block sits on the read side of a quad-data-rate SRAM interface. On each memory clock cycle the read port returns two words. One is valid around the rising edge of the positive echo clock and the other around the rising edge of the complementary echo clock. The block takes the first word on `echo_p` and the second on `echo_n`. It moves the pair into the controller's fast resynchronization domain (`clk_fast`) and then gathers two consecutive pairs into four words on the slow clock (`clk_slow`, half the fast frequency). Either the four slow words or the single fast pair can drive the core-facing outputs, and `fullrate_sel` picks between them at any time.

Each of the three register stages can be bypassed on its own through `stage_bypass`. The capture stage, the resync stage and the slow stage each then pass their input straight through. This lets the interface trade latency against timing margin without any change to the logic. The data width is the parameter `W` and defaults to 9 bits.

The read data is a source-synchronous stream with no valid/ready pair. The memory cannot be stalled, so there is no back-pressure. The core must take the four words on every `clk_slow` cycle, or the pair on every `clk_fast` cycle when the fast output is selected. A pair or quad that is not taken in its cycle is overwritten by the next one.

Top module: `qdr_read_capture`

## Requirements
- R1: While `rst` is high, once it has been seen by two `clk_fast` rising edges, all four output words are zero, whatever `din` carries (no stage bypassed).
- R2: With `fullrate_sel` high and no bypass, `word0` and `word1` carry the rise word and fall word of the pair registered on the latest `clk_fast` rising edge. The rise word is `din` at the `echo_p` rising edge and the fall word is `din` at the `echo_n` rising edge, both of the beat before that `clk_fast` edge. `word2` and `word3` are zero.
- R3: With `fullrate_sel` low, `word0` and `word1` hold the rise and fall words of the earlier beat, and `word2` and `word3` hold the rise and fall words of the later beat.
- R4: `clk_slow` rises together with every second `clk_fast` rising edge. The four slow words change only on a `clk_slow` rising edge and hold for the whole `clk_slow` period. A quad appears exactly one `clk_slow` cycle after the start of the `clk_fast` period in which its later beat is captured.
- R5: A change of `fullrate_sel` switches the outputs at once and leaves the pipeline contents untouched, so the next sample is already correct.
- R6: `stage_bypass` bit 0 bypasses the capture stage. With the resync stage active, both fast words then equal `din` as seen at the `clk_fast` rising edge.
- R7: `stage_bypass` bit 1 bypasses the resync stage. The fast pair then shows a beat as soon as its `echo_n` edge has passed, one `clk_fast` period earlier than in R2.
- R8: `stage_bypass` bit 2 bypasses the slow stage. The four words then follow {previous pair, current pair} from the fast domain and change on every `clk_fast` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high reset, sampled synchronously by every clock domain |
| echo_p | input | 1 | Positive echo clock; its rising edge captures the rise word |
| echo_n | input | 1 | Complementary echo clock; its rising edge captures the fall word and realigns the rise word |
| clk_fast | input | 1 | Full-rate resynchronization clock |
| clk_slow | input | 1 | Half-rate clock, rising with every second `clk_fast` rise |
| din | input | W | Read data bus from the memory |
| stage_bypass | input | 3 | Bit 0 capture, bit 1 resync, bit 2 slow stage; 1 = pass-through |
| fullrate_sel | input | 1 | 1 = fast pair on word0/word1, 0 = slow quad on all four words |
| word0 | output | W | Earlier rise word (slow) or rise word (fast) |
| word1 | output | W | Earlier fall word (slow) or fall word (fast) |
| word2 | output | W | Later rise word (slow), zero in fast mode |
| word3 | output | W | Later fall word (slow), zero in fast mode |

## Verification
The slow-stage assertions assume that `clk_slow` is phase-locked to `clk_fast`, rising on every other fast rising edge. They also assume the echo clocks are complementary and `din` is settled around each echo edge. The bench produces all four clocks from one schedule of fixed phases, so this relation always holds. It changes `din`, `rst`, `stage_bypass` and `fullrate_sel` one nanosecond after an edge and never at one. After a bypass change the bench waits a few fast cycles before it checks the outputs again. It does not wait after a `fullrate_sel` change, because that switch must take effect at once.

// File: rtl/qrc_pkg.sv
package qrc_pkg;
  localparam int BYP_W       = 3;
  localparam int BYP_CAPTURE = 0;
  localparam int BYP_RESYNC  = 1;
  localparam int BYP_SLOW    = 2;
  localparam int LANES       = 2;
  localparam int LANE_RISE   = 0;
  localparam int LANE_FALL   = 1;
  localparam int WORDS       = 2 * LANES;
endpackage

// File: rtl/qrc_stage_reg.sv
module qrc_stage_reg #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bypass,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else     held <= d;
  end

  // pass-through when the stage is bypassed
  assign q = bypass ? d : held;
endmodule

// File: rtl/qrc_capture.sv
module qrc_capture
  import qrc_pkg::*;
#(
  parameter int W = 9
) (
  input  logic                   echo_p,
  input  logic                   echo_n,
  input  logic                   rst,
  input  logic                   bypass,
  input  logic [W-1:0]           din,
  output logic [LANES-1:0][W-1:0] beat_q
);
  logic [W-1:0] rise_early;
  logic [W-1:0] rise_late;
  logic [W-1:0] fall_word;

  // rise word on the positive echo edge
  qrc_stage_reg #(.W(W)) u_rise (
    .clk(echo_p), .rst(rst), .bypass(bypass), .d(din), .q(rise_early)
  );

  // rise word moved onto the complementary edge so both words change together
  qrc_stage_reg #(.W(W)) u_align (
    .clk(echo_n), .rst(rst), .bypass(bypass), .d(rise_early), .q(rise_late)
  );

  // fall word on the complementary echo edge
  qrc_stage_reg #(.W(W)) u_fall (
    .clk(echo_n), .rst(rst), .bypass(bypass), .d(din), .q(fall_word)
  );

  assign beat_q[LANE_RISE] = rise_late;
  assign beat_q[LANE_FALL] = fall_word;
endmodule

// File: rtl/qrc_resync.sv
module qrc_resync
  import qrc_pkg::*;
#(
  parameter int W = 9
) (
  input  logic                    clk_fast,
  input  logic                    rst,
  input  logic                    bypass,
  input  logic [LANES-1:0][W-1:0] beat_d,
  output logic [LANES-1:0][W-1:0] beat_q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    qrc_stage_reg #(.W(W)) u_sync (
      .clk(clk_fast), .rst(rst), .bypass(bypass), .d(beat_d[g]), .q(beat_q[g])
    );
  end
endmodule

// File: rtl/qrc_slow.sv
module qrc_slow
  import qrc_pkg::*;
#(
  parameter int W = 9
) (
  input  logic                    clk_fast,
  input  logic                    clk_slow,
  input  logic                    rst,
  input  logic                    bypass,
  input  logic [LANES-1:0][W-1:0] beat_d,
  output logic [WORDS-1:0][W-1:0] quad_q
);
  logic [LANES-1:0][W-1:0] prev_beat;
  logic [WORDS-1:0][W-1:0] quad_d;

  // two-beat shift stage in the fast domain
  always_ff @(posedge clk_fast) begin
    if (rst) prev_beat <= '0;
    else     prev_beat <= beat_d;
  end

  // earlier beat in the low words, later beat in the high words
  assign quad_d = {beat_d, prev_beat};

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    qrc_stage_reg #(.W(W)) u_half (
      .clk(clk_slow), .rst(rst), .bypass(bypass), .d(quad_d[g]), .q(quad_q[g])
    );
  end

  // R4: slow clock rises on alternate fast edges
  a_r4_slow_phase_up: assert property (@(posedge clk_fast) disable iff (rst)
    !clk_slow |=> clk_slow);
  a_r4_slow_phase_down: assert property (@(posedge clk_fast) disable iff (rst)
    clk_slow |=> !clk_slow);

  // R3: later beat lands in the high words at the slow edge
  a_r3_later_beat_high: assert property (@(posedge clk_fast) disable iff (rst || bypass)
    !clk_slow |=> (quad_q[2] == $past(beat_d[LANE_RISE]) &&
                   quad_q[3] == $past(beat_d[LANE_FALL])));

  // R3: earlier beat lands in the low words at the slow edge
  a_r3_earlier_beat_low: assert property (@(posedge clk_fast) disable iff (rst || bypass)
    !clk_slow |=> (quad_q[0] == $past(prev_beat[LANE_RISE]) &&
                   quad_q[1] == $past(prev_beat[LANE_FALL])));

  // R4: the quad holds across the whole slow period
  a_r4_quad_holds: assert property (@(posedge clk_fast) disable iff (rst || bypass)
    clk_slow |=> $stable(quad_q));
endmodule

// File: rtl/qdr_read_capture.sv
module qdr_read_capture
  import qrc_pkg::*;
#(
  parameter int W = 9
) (
  input  logic             rst,
  input  logic             echo_p,
  input  logic             echo_n,
  input  logic             clk_fast,
  input  logic             clk_slow,
  input  logic [W-1:0]     din,
  input  logic [BYP_W-1:0] stage_bypass,
  input  logic             fullrate_sel,
  output logic [W-1:0]     word0,
  output logic [W-1:0]     word1,
  output logic [W-1:0]     word2,
  output logic [W-1:0]     word3
);
  logic [LANES-1:0][W-1:0] cap_beat;
  logic [LANES-1:0][W-1:0] sync_beat;
  logic [WORDS-1:0][W-1:0] slow_quad;
  logic [WORDS-1:0][W-1:0] out_quad;

  qrc_capture #(.W(W)) u_capture (
    .echo_p(echo_p), .echo_n(echo_n), .rst(rst),
    .bypass(stage_bypass[BYP_CAPTURE]), .din(din), .beat_q(cap_beat)
  );

  qrc_resync #(.W(W)) u_resync (
    .clk_fast(clk_fast), .rst(rst), .bypass(stage_bypass[BYP_RESYNC]),
    .beat_d(cap_beat), .beat_q(sync_beat)
  );

  qrc_slow #(.W(W)) u_slow (
    .clk_fast(clk_fast), .clk_slow(clk_slow), .rst(rst),
    .bypass(stage_bypass[BYP_SLOW]), .beat_d(sync_beat), .quad_q(slow_quad)
  );

  // run-time choice between the fast pair and the slow quad
  always_comb begin
    if (fullrate_sel) out_quad = {{LANES{W'(0)}}, sync_beat};
    else              out_quad = slow_quad;
  end

  assign word0 = out_quad[0];
  assign word1 = out_quad[1];
  assign word2 = out_quad[2];
  assign word3 = out_quad[3];
endmodule

// File: tb/qdr_read_capture_tb_top.sv
module qdr_read_capture_tb_top;
  localparam int W = 9;
  localparam int NROW = 8;
  localparam int HIST = 512;

  // rows: {late fall, late rise, early fall, early rise}
  localparam logic [3:0][W-1:0] TBL [NROW] = '{
    {9'h1ff, 9'h000, 9'h155, 9'h0aa},
    {9'h001, 9'h100, 9'h002, 9'h080},
    {9'h123, 9'h045, 9'h067, 9'h189},
    {9'h0f0, 9'h10f, 9'h033, 9'h1cc},
    {9'h000, 9'h000, 9'h1ff, 9'h1ff},
    {9'h111, 9'h022, 9'h144, 9'h088},
    {9'h0e1, 9'h1d2, 9'h0c3, 9'h1b4},
    {9'h101, 9'h0fe, 9'h17d, 9'h082}
  };

  logic         rst = 1'b1;
  logic         echo_p = 1'b0;
  logic         echo_n = 1'b1;
  logic         clk_fast = 1'b0;
  logic         clk_slow = 1'b0;
  logic [W-1:0] din = '0;
  logic [2:0]   stage_bypass = '0;
  logic         fullrate_sel = 1'b0;
  logic [W-1:0] word0, word1, word2, word3;

  logic         nx_rst = 1'b1;
  logic [2:0]   nx_byp = '0;
  logic         nx_fsel = 1'b0;
  logic         fsel_moved = 1'b0;
  int           cyc = 0;
  int           quiet = 0;
  int           rst_age = 0;
  int           total = 0;
  int           bad = 0;
  logic [W-1:0] hr [HIST];
  logic [W-1:0] hf [HIST];

  qdr_read_capture #(.W(W)) dut_i (
    .rst(rst), .echo_p(echo_p), .echo_n(echo_n), .clk_fast(clk_fast),
    .clk_slow(clk_slow), .din(din), .stage_bypass(stage_bypass),
    .fullrate_sel(fullrate_sel), .word0(word0), .word1(word1),
    .word2(word2), .word3(word3)
  );

  function automatic logic [W-1:0] br(input int k);
    return (k < 0) ? '0 : hr[k];
  endfunction

  function automatic logic [W-1:0] bf(input int k);
    return (k < 0) ? '0 : hf[k];
  endfunction

  task automatic chk(input string tag, input logic [4*W-1:0] exp);
    logic [4*W-1:0] act;
    act = {word0, word1, word2, word3};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cyc=%0d act=%h exp=%h", tag, cyc, act, exp);
    end
  endtask

  // check slot near the start of a fast cycle (slow quad, R3)
  task automatic slot_a();
    if (!rst && quiet == 0 && !fullrate_sel && stage_bypass == 3'b000 && cyc % 2 == 0)
      chk(fsel_moved ? "R5" : "R3",
          {br(cyc-3), bf(cyc-3), br(cyc-2), bf(cyc-2)});
  endtask

  // check slot just after the complementary echo edge
  task automatic slot_b();
    int ce;
    if (rst) begin
      if (rst_age >= 2) chk("R1", '0);
    end else if (quiet == 0) begin
      if (fullrate_sel) begin
        case (stage_bypass)
          3'b000: chk(fsel_moved ? "R5" : "R2", {br(cyc-1), bf(cyc-1), W'(0), W'(0)});
          3'b001: chk("R6", {bf(cyc-1), bf(cyc-1), W'(0), W'(0)});
          3'b010: chk("R7", {br(cyc), bf(cyc), W'(0), W'(0)});
          default: ;
        endcase
      end else begin
        ce = cyc - (cyc % 2);
        case (stage_bypass)
          3'b000: chk(fsel_moved ? "R5" : "R4", {br(ce-3), bf(ce-3), br(ce-2), bf(ce-2)});
          3'b100: chk("R8", {br(cyc-2), bf(cyc-2), br(cyc-1), bf(cyc-1)});
          default: ;
        endcase
      end
    end
  endtask

  // one 20 ns fast cycle: four 5 ns phases, inputs moved 1 ns after edges
  task automatic run_cycle(input logic [W-1:0] r, input logic [W-1:0] f);
    clk_fast = 1'b1;
    clk_slow = (cyc % 2 == 0);
    #1;
    fsel_moved   = (nx_fsel != fullrate_sel);
    rst          = nx_rst;
    stage_bypass = nx_byp;
    fullrate_sel = nx_fsel;
    din          = r;
    hr[cyc]      = nx_rst ? '0 : r;
    hf[cyc]      = nx_rst ? '0 : f;
    #1 slot_a();
    #3 echo_p = 1'b1; echo_n = 1'b0;
    #5 clk_fast = 1'b0;
    #1 din = f;
    #4 echo_p = 1'b0; echo_n = 1'b1;
    #2 slot_b();
    #3;
    if (quiet > 0) quiet--;
    rst_age = rst ? rst_age + 1 : 0;
    cyc++;
  endtask

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog R1 act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset with idle bus (R1)
    for (int i = 0; i < 6; i++) run_cycle('0, '0);
    nx_rst = 1'b0;
    run_cycle('0, '0);

    // table walk: early beat on odd cycles so each row forms one quad (R3, R4)
    for (int i = 0; i < NROW; i++) begin
      run_cycle(TBL[i][0], TBL[i][1]);
      run_cycle(TBL[i][2], TBL[i][3]);
    end
    for (int i = 0; i < 4; i++) run_cycle(W'(i * 29 + 3), W'(i * 41 + 7));

    // fast pair output, switched at run time (R2, R5)
    nx_fsel = 1'b1;
    for (int i = 0; i < 12; i++) begin
      if (i % 3 == 2) nx_fsel = ~nx_fsel;
      run_cycle(W'(i * 37 + 5), W'(i * 53 + 11));
    end

    // capture stage bypassed, fast output (R6)
    nx_fsel = 1'b1; nx_byp = 3'b001; quiet = 4;
    for (int i = 0; i < 10; i++) run_cycle(W'(i * 71 + 9), W'(i * 19 + 200));

    // resync stage bypassed (R7)
    nx_byp = 3'b010; quiet = 4;
    for (int i = 0; i < 10; i++) run_cycle(W'(i * 23 + 100), W'(i * 67 + 1));

    // slow stage bypassed, quad output (R8)
    nx_fsel = 1'b0; nx_byp = 3'b100; quiet = 4;
    for (int i = 0; i < 10; i++) run_cycle(W'(i * 13 + 300), W'(i * 91 + 17));

    // back to normal, then reset in mid-stream with busy bus (R1)
    nx_byp = 3'b000; quiet = 4;
    for (int i = 0; i < 6; i++) run_cycle(W'(i * 7 + 400), W'(i * 11 + 50));
    nx_rst = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (i == 3) nx_fsel = 1'b1;
      run_cycle(9'h1ff, 9'h155);
    end
    nx_rst = 1'b0; nx_fsel = 1'b0;
    for (int i = 0; i < 8; i++) run_cycle(W'(i * 59 + 2), W'(i * 31 + 77));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule